// File: doc/BRIEF.md
# Fail-Safe Clock Monitor

This block watches the primary system clock and decides whether it has stopped or has slowed past a fixed limit. It judges the primary clock against a slow sample clock. The sample clock comes from a low-frequency reference clock that runs all the time, divided by a parameter (64 by default). An edge latch is cleared at each rising edge of the sample clock. Any falling edge of the primary clock sets it. When the sample clock falls, the monitor reads the latch. If no primary falling edge has arrived during that high half, the monitor declares a failure.

On a failure the block does several things. It sets a sticky fail flag and raises an interrupt request if interrupts are enabled. It enters a fail-safe state, which drives an override that moves the system clock onto the internal oscillator. It also sends one-cycle pulses that clear the watchdog and the start-up status. The fail-safe state holds even if the primary clock comes back. Only reset, a sleep event or a write to the clock-select setting ends it. The fail flag cannot be cleared while the fail-safe state holds.

All control logic runs on the reference clock. The latch decision crosses into that domain through a synchroniser before it can drive the clock override. The strobes for sleep, clock-select write and flag clear are synchronous to the reference clock.

Top module: `fail_safe_clock_monitor`

## Requirements
- R1: While `rstN` is low, and after it is released, `failFlag`, `failSafe`, `clkOverride`, `irq`, `wdtClr` and `startStatClr` are 0. Reset also ends a fail-safe state that is in progress.
- R2: When the primary clock has a falling edge within every evaluation window, no failure is ever declared. The evaluation window is the high half of the sample clock (reference period times `DIV`), shortened by the synchroniser latency.
- R3: When the primary clock stops, or its period is longer than several sample periods, a failure is declared within three sample periods.
- R4: No failure is declared while `enable` is 0 or while `startupDone` is 0. Once both are 1, monitoring is armed at the next sample-clock rising edge.
- R5: On a failure, `failFlag`, `failSafe` and `clkOverride` become 1. `wdtClr` and `startStatClr` each pulse high for exactly one reference cycle, once per failure.
- R6: `irq` is 1 exactly when `failFlag` is 1 and `irqEn` is 1.
- R7: `failSafe` stays 1 after the primary clock resumes. A `sleepEvt` or `clkSelWr` pulse ends it at the next reference edge, and it otherwise holds.
- R8: `flagClr` has no effect on `failFlag` while `failSafe` is 1. When `failSafe` is 0, `flagClr` clears `failFlag` at the next reference edge.
- R9: `twoSpeedEn` follows `enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Low-frequency reference clock; clocks all control logic |
| rstN | input | 1 | Asynchronous active-low reset |
| priClk | input | 1 | Primary system clock under observation |
| enable | input | 1 | Monitor enable |
| startupDone | input | 1 | Start-up timer expired (tie high for modes without one) |
| sleepEvt | input | 1 | One-cycle sleep event; ends the fail-safe state |
| clkSelWr | input | 1 | One-cycle clock-select write strobe; ends the fail-safe state |
| flagClr | input | 1 | Request to clear the fail flag |
| irqEn | input | 1 | Interrupt enable for the fail flag |
| failFlag | output | 1 | Sticky oscillator-fail flag |
| failSafe | output | 1 | Fail-safe state |
| clkOverride | output | 1 | Forces the system clock onto the internal oscillator |
| wdtClr | output | 1 | One-cycle watchdog clear pulse on failure |
| startStatClr | output | 1 | One-cycle start-up status clear pulse on failure |
| irq | output | 1 | Interrupt request |
| twoSpeedEn | output | 1 | Two-speed start-up enable |

## Verification
The bench builds the monitor with `DIV` = 16 and two synchroniser stages. This makes a sample period 16 reference cycles long, so a run can cover dozens of evaluation windows and many failure-and-recovery rounds. With these values a primary clock several times faster than the reference stays comfortably inside the window. A primary clock with a period of four sample periods misses whole windows, and a stopped clock misses all of them, so both sides of the threshold are reached in a short run. The failure latency bound of three sample periods is then only 48 cycles, which the bench polls directly.

// File: rtl/fscm_pkg.sv
package fscm_pkg;
  // Sample-clock events passed from the sampling datapath to the control.
  typedef struct packed {
    logic sampleRise;   // sample clock rising: latch cleared, window opens
    logic sampleFall;   // sample clock falling: window closes, verdict due
    logic primarySeen;  // synchronised latch: a primary falling edge arrived
  } sample_evt_t;
endpackage

// File: rtl/fscm_sampler.sv
module fscm_sampler
  import fscm_pkg::*;
#(
  parameter int DIV         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        refClk,
  input  logic        rstN,
  input  logic        priClk,
  output sample_evt_t evt
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF  = DIV / 2;

  logic [CNT_W-1:0] divCnt;
  logic             riseAt;
  logic             fallAt;
  logic             latchClr;
  logic             edgeLatch;
  logic [SYNC_STAGES-1:0] seenSync;

  assign riseAt = (divCnt == CNT_W'(DIV - 1));
  assign fallAt = (divCnt == CNT_W'(HALF - 1));

  // Reference divider: one full sample-clock period per DIV reference cycles.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)       divCnt <= '0;
    else if (riseAt) divCnt <= '0;
    else             divCnt <= divCnt + 1'b1;
  end

  // Clear pulse aligned to the sample-clock rising edge; held during reset.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) latchClr <= 1'b1;
    else       latchClr <= riseAt;
  end

  // Edge latch: set by any primary falling edge, cleared asynchronously.
  always_ff @(negedge priClk or posedge latchClr) begin
    if (latchClr) edgeLatch <= 1'b0;
    else          edgeLatch <= 1'b1;
  end

  // Bring the latch into the reference domain.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) seenSync <= '0;
    else       seenSync <= {seenSync[SYNC_STAGES-2:0], edgeLatch};
  end

  assign evt.sampleRise  = riseAt;
  assign evt.sampleFall  = fallAt;
  assign evt.primarySeen = seenSync[SYNC_STAGES-1];

  // R2: windows stay long enough to outlast the synchroniser
  initial begin
    a_r2_window_fits : assert (HALF > SYNC_STAGES + 1);
  end
endmodule

// File: rtl/fscm_ctrl.sv
module fscm_ctrl
  import fscm_pkg::*;
(
  input  logic        refClk,
  input  logic        rstN,
  input  sample_evt_t evt,
  input  logic        enable,
  input  logic        startupDone,
  input  logic        sleepEvt,
  input  logic        clkSelWr,
  input  logic        flagClr,
  input  logic        irqEn,
  output logic        failFlag,
  output logic        failSafe,
  output logic        clkOverride,
  output logic        wdtClr,
  output logic        startStatClr,
  output logic        irq,
  output logic        twoSpeedEn
);
  logic active;
  logic armed;
  logic exitReq;
  logic failDet;
  logic failPulse;

  assign active  = enable & startupDone & ~failSafe;
  assign exitReq = sleepEvt | clkSelWr;
  assign failDet = evt.sampleFall & armed & active & ~evt.primarySeen & ~exitReq;

  // Arm only after a full window has started under monitoring.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)               armed <= 1'b0;
    else if (!active)        armed <= 1'b0;
    else if (evt.sampleRise) armed <= 1'b1;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)        failSafe <= 1'b0;
    else if (exitReq) failSafe <= 1'b0;
    else if (failDet) failSafe <= 1'b1;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                     failFlag <= 1'b0;
    else if (failDet)              failFlag <= 1'b1;
    else if (flagClr && !failSafe) failFlag <= 1'b0;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) failPulse <= 1'b0;
    else       failPulse <= failDet;
  end

  assign clkOverride  = failSafe;
  assign wdtClr       = failPulse;
  assign startStatClr = failPulse;
  assign irq          = failFlag & irqEn;
  assign twoSpeedEn   = enable;

  a_r8_flag_held : assert property (@(posedge refClk) disable iff (!rstN)
    failSafe |-> failFlag);
  a_r7_exit_next : assert property (@(posedge refClk) disable iff (!rstN)
    (failSafe && (sleepEvt || clkSelWr)) |=> !failSafe);
  a_r7_no_self_exit : assert property (@(posedge refClk) disable iff (!rstN)
    (failSafe && !sleepEvt && !clkSelWr) |=> failSafe);
  a_r4_fail_only_enabled : assert property (@(posedge refClk) disable iff (!rstN)
    $rose(failSafe) |-> $past(evt.sampleFall && !evt.primarySeen && enable && startupDone));
  a_r5_single_pulse : assert property (@(posedge refClk) disable iff (!rstN)
    wdtClr |=> !wdtClr);
endmodule

// File: rtl/fail_safe_clock_monitor.sv
module fail_safe_clock_monitor
  import fscm_pkg::*;
#(
  parameter int DIV         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic priClk,
  input  logic enable,
  input  logic startupDone,
  input  logic sleepEvt,
  input  logic clkSelWr,
  input  logic flagClr,
  input  logic irqEn,
  output logic failFlag,
  output logic failSafe,
  output logic clkOverride,
  output logic wdtClr,
  output logic startStatClr,
  output logic irq,
  output logic twoSpeedEn
);
  sample_evt_t evt;

  fscm_sampler #(.DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .refClk (refClk),
    .rstN   (rstN),
    .priClk (priClk),
    .evt    (evt)
  );

  fscm_ctrl u_ctrl (
    .refClk       (refClk),
    .rstN         (rstN),
    .evt          (evt),
    .enable       (enable),
    .startupDone  (startupDone),
    .sleepEvt     (sleepEvt),
    .clkSelWr     (clkSelWr),
    .flagClr      (flagClr),
    .irqEn        (irqEn),
    .failFlag     (failFlag),
    .failSafe     (failSafe),
    .clkOverride  (clkOverride),
    .wdtClr       (wdtClr),
    .startStatClr (startStatClr),
    .irq          (irq),
    .twoSpeedEn   (twoSpeedEn)
  );
endmodule

// File: tb/fail_safe_clock_monitor_test.sv
`timescale 1ns/1ps
module fail_safe_clock_monitor_test;
  localparam int DIV = 16;

  logic refClk = 1'b0;
  logic priClk = 1'b0;
  logic rstN, enable, startupDone, sleepEvt, clkSelWr, flagClr, irqEn;
  logic failFlag, failSafe, clkOverride, wdtClr, startStatClr, irq, twoSpeedEn;
  logic priRun = 1'b1;
  int   priHalf = 3;
  int   checks = 0;
  int   errors = 0;
  int   wdtCount = 0;
  int   stsCount = 0;
  logic finished = 1'b0;

  fail_safe_clock_monitor #(.DIV(DIV), .SYNC_STAGES(2)) uut (
    .refClk(refClk), .rstN(rstN), .priClk(priClk), .enable(enable),
    .startupDone(startupDone), .sleepEvt(sleepEvt), .clkSelWr(clkSelWr),
    .flagClr(flagClr), .irqEn(irqEn), .failFlag(failFlag), .failSafe(failSafe),
    .clkOverride(clkOverride), .wdtClr(wdtClr), .startStatClr(startStatClr),
    .irq(irq), .twoSpeedEn(twoSpeedEn)
  );

  always #5 refClk = ~refClk;

  initial begin
    forever begin
      if (priRun) #(priHalf) priClk = ~priClk;
      else        #5;
    end
  end

  always @(negedge refClk) begin
    if (wdtClr)       wdtCount++;
    if (startStatClr) stsCount++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge refClk);
    s = 1'b0;
    @(negedge refClk);
  endtask

  task automatic waitFail(output int seen);
    seen = 0;
    for (int i = 0; i < 3 * DIV + 4; i++) begin
      @(negedge refClk);
      if (failSafe) begin
        seen = 1;
        break;
      end
    end
  endtask

  initial begin
    int got;
    rstN = 0; enable = 1; startupDone = 1; sleepEvt = 0; clkSelWr = 0;
    flagClr = 0; irqEn = 1;
    cyc(5);
    chk("R1 failSafe in reset", failSafe, 0);
    chk("R1 failFlag in reset", failFlag, 0);
    chk("R1 override in reset", clkOverride, 0);
    chk("R1 irq in reset", irq, 0);
    chk("R1 pulses in reset", wdtCount + stsCount, 0);
    rstN = 1;
    cyc(1);
    chk("R9 twoSpeedEn on", twoSpeedEn, 1);

    // running primary: never fails
    cyc(10 * DIV);
    chk("R2 fast primary failSafe", failSafe, 0);
    chk("R2 fast primary flag", failFlag, 0);

    // stop primary
    priRun = 0;
    waitFail(got);
    chk("R3 stopped primary detected", got, 1);
    chk("R5 flag set", failFlag, 1);
    chk("R5 override set", clkOverride, 1);
    chk("R6 irq with enable", irq, 1);
    cyc(4);
    chk("R5 one wdtClr pulse", wdtCount, 1);
    chk("R5 one startStatClr pulse", stsCount, 1);

    pulse(flagClr);
    chk("R8 flagClr ignored in fail-safe", failFlag, 1);

    priRun = 1;
    cyc(6 * DIV);
    chk("R7 holds after primary resumes", failSafe, 1);

    pulse(clkSelWr);
    chk("R7 clkSelWr exits", failSafe, 0);
    chk("R7 override dropped", clkOverride, 0);
    chk("R8 flag kept after exit", failFlag, 1);
    pulse(flagClr);
    chk("R8 flagClr clears", failFlag, 0);
    chk("R6 irq follows flag", irq, 0);

    // second failure with interrupt masked
    irqEn = 0;
    priRun = 0;
    waitFail(got);
    chk("R3 second detection", got, 1);
    chk("R6 irq masked", irq, 0);
    cyc(4);
    chk("R5 second wdtClr pulse", wdtCount, 2);

    enable = 0;
    cyc(1);
    chk("R9 twoSpeedEn off", twoSpeedEn, 0);
    pulse(sleepEvt);
    chk("R7 sleep exits", failSafe, 0);
    pulse(flagClr);
    chk("R8 flag cleared", failFlag, 0);
    cyc(6 * DIV);
    chk("R4 disabled no failure", failSafe, 0);
    chk("R4 disabled no flag", failFlag, 0);

    enable = 1; startupDone = 0;
    cyc(6 * DIV);
    chk("R4 start-up pending no failure", failSafe, 0);
    startupDone = 1;
    waitFail(got);
    chk("R4 detection after start-up", got, 1);

    rstN = 0;
    cyc(2);
    chk("R1 reset exits fail-safe", failSafe, 0);
    chk("R1 reset clears flag", failFlag, 0);

    // slow primary: period of four sample periods
    priHalf = DIV * 20;
    priRun = 1;
    rstN = 1;
    waitFail(got);
    if (!got) waitFail(got);
    chk("R3 slow primary detected", got, 1);

    priHalf = 3;
    cyc(4);
    pulse(clkSelWr);
    pulse(flagClr);
    cyc(8 * DIV);
    chk("R2 recovered primary no failure", failSafe, 0);
    chk("R2 recovered primary flag", failFlag, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule